// File: doc/BRIEF.md
# BCD Calendar Timekeeper With Serial Access

This block keeps calendar time in packed BCD. It counts hundredths of a second, seconds, minutes, hours, day of week, date, month and year. It is driven by a single-cycle pulse that marks each edge of a 32.768 kHz time base. A fractional accumulator turns that rate into exactly one hundred hundredth-of-second steps for every 32768 time-base pulses. The calendar handles months of different lengths and February 29 in leap years. Hours can be counted in a 24-hour format or in a 12-hour format with a PM flag.

Software sees the whole calendar as one 64-bit image of eight bytes. Byte k holds image bits 8k to 8k+7, least significant bit first:

- byte 0: hundredths
- byte 1: seconds
- byte 2: minutes
- byte 3: hours
- byte 4: day of week and control
- byte 5: date
- byte 6: month
- byte 7: year

The image is accessed one bit at a time through a bit index. A start pulse freezes a snapshot of the live counters for coherent reads. Writes collect in that snapshot and are committed together when bit 63 is written.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the image reads as year 00, month 01, date 01, day byte 01, hours 00, minutes 00, seconds 00, hundredths 00.
- R2: A pulse on `acc_start_i` copies the live image into a snapshot. While `acc_start_i` is low, `rd_bit_o` shows snapshot bit `bit_idx_i`, where index 8k+j is bit j of byte k.
- R3: Bits that have no meaning always read as 0. The masks are: seconds and minutes 0x7F, hours 0xBF, day byte 0x37, date 0x3F, month 0x1F. Hundredths and year keep all eight bits.
- R4: Time advances by one hundredth on the 328th time-base pulse after a commit. Exactly 100 hundredths elapse over 32768 pulses.
- R5: When hours bit 7 is 0 (24-hour format), the hour runs 00 to 23. Leaving 23 gives 00 and advances the date.
- R6: Hundredths wrap 99 to 00, seconds and minutes wrap 59 to 00, month wraps 12 to 01, and year wraps 99 to 00. Each wrap carries into the next field.
- R7: When hours bit 7 is 1 (12-hour format), bit 5 is the PM flag and the hour runs 01 to 12. The sequence is 11 AM to 12 PM, 12 to 01 with the flag unchanged, and 11 PM to 12 AM. Only the 11 PM step advances the date. For example, 12 PM is 0xB2.
- R8: The day of week, in day-byte bits 2:0, steps once per date advance and goes from 7 back to 1.
- R9: Months 04, 06, 09 and 11 end on the 30th. February ends on the 29th when the BCD year is a multiple of four (00 included), and on the 28th otherwise. All other months end on the 31st.
- R10: While day-byte bit 5 is 1, the oscillator is treated as stopped and the counters do not advance.
- R11: The snapshot does not change while time advances. Only a new start pulse refreshes it.
- R12: A write strobe stores `wr_bit_i` at `bit_idx_i` in the snapshot. A write to index 63 loads the whole snapshot into the counters and clears the hundredth accumulator. Writes to other indices leave the counters untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz time-base edge |
| acc_start_i | input | 1 | Starts an access: snapshot the live image |
| bit_idx_i | input | 6 | Serial bit index into the 64-bit image |
| wr_en_i | input | 1 | Write strobe for the indexed bit |
| wr_bit_i | input | 1 | Write data bit |
| rd_bit_o | output | 1 | Snapshot bit at `bit_idx_i` (combinational) |

## Verification
Each result has a fixed due time:

- Snapshot: taken at the clock edge that samples `acc_start_i`. The read bit follows the index combinationally, so the bench changes the index between edges and samples one nanosecond later.
- Commit: happens at the edge that samples the write to bit 63. The accumulator restarts at that same edge.
- First hundredth: the calendar steps on the very edge that samples the 328th pulse. A full cascade also settles on that edge, because all carries are resolved in one cycle.

The bench drives exact counts of pulses: 327 and then one more, 328 for rollovers, and 32768 for the long-run rate. It then takes a fresh snapshot with the pulse input idle, so no extra edge can move the counters before readback.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int IMG_BITS = 64;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = $clog2(IMG_BITS);

  typedef struct packed {
    logic [BYTE_W-1:0] year;
    logic [BYTE_W-1:0] month;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] day;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] minute;
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] hund;
  } tk_time_t;

  // Bits with meaning in each byte; others are held at zero.
  localparam logic [IMG_BITS-1:0] IMG_MASK = 64'hFF1F_3F37_BF7F_7FFF;
  localparam logic [IMG_BITS-1:0] RST_IMG  = 64'h0001_0101_0000_0000;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year mod 4: 10 == 2 (mod 4), so (2*tens + ones) mod 4.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [2:0] s;
    s = {1'b0, yr[4], 1'b0} + {1'b0, yr[1:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/tk_divider.sv
module tk_divider #(
  parameter int MOD  = 32768,
  parameter int STEP = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic hund_o
);
  localparam int W = $clog2(MOD) + 1;

  logic [W-1:0] acc_q, acc_d, sum;
  logic         wrap;

  always_comb begin
    sum    = acc_q + W'(STEP);
    wrap   = (sum >= W'(MOD));
    hund_o = tick_i && !clr_i && wrap;
    acc_d  = acc_q;
    if (clr_i)       acc_d = '0;
    else if (tick_i) acc_d = wrap ? (sum - W'(MOD)) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R4
  hund_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hund_o |=> !hund_o);
endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
  import tk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hund_i,
  input  logic                load_i,
  input  logic [IMG_BITS-1:0] load_img_i,
  output logic [IMG_BITS-1:0] img_o
);
  tk_time_t q, d;
  logic c_s, c_m, c_h, c_d, c_mo, c_y;
  logic [7:0] h12, hn;

  always_comb begin
    d = q;
    c_s = 1'b0; c_m = 1'b0; c_h = 1'b0; c_d = 1'b0; c_mo = 1'b0; c_y = 1'b0;
    h12 = {3'b000, q.hour[4:0]};
    hn  = 8'h00;
    if (hund_i) begin
      if (q.hund == 8'h99) begin d.hund = 8'h00; c_s = 1'b1; end
      else                       d.hund = bcd_inc(q.hund);
    end
    if (c_s) begin
      if (q.sec == 8'h59) begin d.sec = 8'h00; c_m = 1'b1; end
      else                      d.sec = bcd_inc(q.sec);
    end
    if (c_m) begin
      if (q.minute == 8'h59) begin d.minute = 8'h00; c_h = 1'b1; end
      else                         d.minute = bcd_inc(q.minute);
    end
    if (c_h) begin
      if (q.hour[7]) begin
        if (h12 == 8'h11) begin
          d.hour = {1'b1, 1'b0, ~q.hour[5], 5'h12};
          c_d    = q.hour[5];
        end else if (h12 == 8'h12) begin
          d.hour = {1'b1, 1'b0, q.hour[5], 5'h01};
        end else begin
          hn     = bcd_inc(h12);
          d.hour = {1'b1, 1'b0, q.hour[5], hn[4:0]};
        end
      end else begin
        if (q.hour[5:0] == 6'h23) begin
          d.hour = 8'h00;
          c_d    = 1'b1;
        end else begin
          hn     = bcd_inc({2'b00, q.hour[5:0]});
          d.hour = {2'b00, hn[5:0]};
        end
      end
    end
    if (c_d) begin
      d.day[2:0] = (q.day[2:0] >= 3'd7) ? 3'd1 : q.day[2:0] + 3'd1;
      if (q.date == month_last(q.month, q.year)) begin d.date = 8'h01; c_mo = 1'b1; end
      else                                             d.date = bcd_inc(q.date);
    end
    if (c_mo) begin
      if (q.month == 8'h12) begin d.month = 8'h01; c_y = 1'b1; end
      else                        d.month = bcd_inc(q.month);
    end
    if (c_y) d.year = (q.year == 8'h99) ? 8'h00 : bcd_inc(q.year);
    if (load_i) d = tk_time_t'(load_img_i & IMG_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= tk_time_t'(RST_IMG);
    else        q <= d;
  end

  assign img_o = q;

  // R6
  hund_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hund_i && !load_i && q.hund == 8'h99) |=> (q.hund == 8'h00));
  // R7
  pm_midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hund_i && !load_i && q.hour == 8'hB1 && q.minute == 8'h59 &&
     q.sec == 8'h59 && q.hund == 8'h99) |=> (q.hour == 8'h92));
endmodule

// File: rtl/tk_serial_port.sv
module tk_serial_port
  import tk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [IMG_BITS-1:0] live_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                wr_en_i,
  input  logic                wr_bit_i,
  output logic                rd_bit_o,
  output logic                load_o,
  output logic [IMG_BITS-1:0] load_img_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_BITS - 1);

  logic [IMG_BITS-1:0] shadow_q, shadow_d, wr_img;

  always_comb begin
    wr_img         = shadow_q;
    wr_img[idx_i]  = wr_bit_i;
    shadow_d       = shadow_q;
    if (start_i)      shadow_d = live_i;
    else if (wr_en_i) shadow_d = wr_img;
    load_o     = wr_en_i && !start_i && (idx_i == LAST_IDX);
    load_img_o = wr_img;
    rd_bit_o   = shadow_q[idx_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !wr_en_i) |=> $stable(shadow_q));
  // R2
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (shadow_q == $past(live_i)));
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int TB_HZ    = 32768,
  parameter int HUND_PER = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             acc_start_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             wr_en_i,
  input  logic             wr_bit_i,
  output logic             rd_bit_o
);
  localparam int OSC_OFF_BIT = 4 * BYTE_W + 5;

  logic [IMG_BITS-1:0] live_img, load_img;
  logic                load, hund_tick, osc_run;

  assign osc_run = !live_img[OSC_OFF_BIT];

  tk_divider #(.MOD(TB_HZ), .STEP(HUND_PER)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_i(load),
    .tick_i(tick_i && osc_run), .hund_o(hund_tick)
  );

  tk_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .hund_i(hund_tick), .load_i(load),
    .load_img_i(load_img), .img_o(live_img)
  );

  tk_serial_port u_port (
    .clk(clk), .rst_n(rst_n), .start_i(acc_start_i), .live_i(live_img),
    .idx_i(bit_idx_i), .wr_en_i(wr_en_i), .wr_bit_i(wr_bit_i),
    .rd_bit_o(rd_bit_o), .load_o(load), .load_img_o(load_img)
  );

  // R10
  osc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !osc_run) |=> $stable(live_img));
  // R12
  partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && bit_idx_i != IDX_W'(IMG_BITS - 1) && !osc_run) |=> $stable(live_img));
endmodule

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       acc_start_i = 1'b0;
  logic [5:0] bit_idx_i = '0;
  logic       wr_en_i = 1'b0;
  logic       wr_bit_i = 1'b0;
  logic       rd_bit_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  bcd_timekeeper u_bcd_timekeeper (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .acc_start_i(acc_start_i),
    .bit_idx_i(bit_idx_i), .wr_en_i(wr_en_i), .wr_bit_i(wr_bit_i), .rd_bit_o(rd_bit_o)
  );

  function automatic logic [63:0] mk(input logic [7:0] y, mo, dt, dw, h, mi, s, hu);
    return {y, mo, dt, dw, h, mi, s, hu};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write_bits(input logic [63:0] img, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      wr_en_i = 1'b1; bit_idx_i = 6'(i); wr_bit_i = img[i];
    end
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic read_img(input logic fresh, output logic [63:0] img);
    if (fresh) begin
      @(negedge clk); acc_start_i = 1'b1;
      @(negedge clk); acc_start_i = 1'b0;
    end
    for (int i = 0; i < 64; i++) begin
      bit_idx_i = 6'(i);
      #1 img[i] = rd_bit_o;
    end
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic roll(input string tag, input logic [63:0] from, input logic [63:0] to);
    logic [63:0] r;
    write_bits(from, 64);
    run_ticks(328);
    read_img(1'b1, r);
    chk(tag, r, to);
  endtask

  task automatic t_reset();
    logic [63:0] r;
    read_img(1'b1, r);
    chk("R1 reset image", r, 64'h0001_0101_0000_0000);
  endtask

  task automatic t_mask_and_order();
    logic [63:0] r, v;
    write_bits({64{1'b1}}, 64);
    read_img(1'b1, r);
    chk("R3 unused bits zero", r, 64'hFF1F_3F37_BF7F_7FFF);
    v = mk(8'h47, 8'h09, 8'h18, 8'h06, 8'h13, 8'h42, 8'h07, 8'h56);
    write_bits(v, 64);
    read_img(1'b1, r);
    chk("R2 byte order readback", r, v);
  endtask

  task automatic t_divider();
    logic [63:0] r;
    write_bits(mk(8'h24, 8'h01, 8'h01, 8'h01, 8'h10, 8'h20, 8'h30, 8'h00), 64);
    run_ticks(327);
    read_img(1'b1, r);
    chk("R4 no step at 327", r, mk(8'h24, 8'h01, 8'h01, 8'h01, 8'h10, 8'h20, 8'h30, 8'h00));
    run_ticks(1);
    read_img(1'b1, r);
    chk("R4 step at 328", r, mk(8'h24, 8'h01, 8'h01, 8'h01, 8'h10, 8'h20, 8'h30, 8'h01));
    write_bits(mk(8'h24, 8'h01, 8'h01, 8'h01, 8'h10, 8'h20, 8'h30, 8'h00), 64);
    run_ticks(32768);
    read_img(1'b1, r);
    chk("R4 one second per 32768", r, mk(8'h24, 8'h01, 8'h01, 8'h01, 8'h10, 8'h20, 8'h31, 8'h00));
  endtask

  task automatic t_cascade();
    roll("R5 R6 R8 full year wrap",
         mk(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99),
         mk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    roll("R5 hour 09 to 10",
         mk(8'h24, 8'h05, 8'h10, 8'h03, 8'h09, 8'h59, 8'h59, 8'h99),
         mk(8'h24, 8'h05, 8'h10, 8'h03, 8'h10, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_twelve_hour();
    roll("R7 11PM to 12AM",
         mk(8'h24, 8'h03, 8'h15, 8'h02, 8'hB1, 8'h59, 8'h59, 8'h99),
         mk(8'h24, 8'h03, 8'h16, 8'h03, 8'h92, 8'h00, 8'h00, 8'h00));
    roll("R7 11AM to 12PM",
         mk(8'h24, 8'h03, 8'h15, 8'h02, 8'h91, 8'h59, 8'h59, 8'h99),
         mk(8'h24, 8'h03, 8'h15, 8'h02, 8'hB2, 8'h00, 8'h00, 8'h00));
    roll("R7 12PM to 01PM",
         mk(8'h24, 8'h03, 8'h15, 8'h02, 8'hB2, 8'h59, 8'h59, 8'h99),
         mk(8'h24, 8'h03, 8'h15, 8'h02, 8'hA1, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_month_len();
    roll("R9 Feb 28 non-leap",
         mk(8'h23, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59, 8'h99),
         mk(8'h23, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00));
    roll("R9 Feb 28 leap",
         mk(8'h24, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59, 8'h99),
         mk(8'h24, 8'h02, 8'h29, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00));
    roll("R9 Feb 28 year 00",
         mk(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
         mk(8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
    roll("R9 Apr 30",
         mk(8'h24, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99),
         mk(8'h24, 8'h05, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00));
    roll("R9 Jul 30",
         mk(8'h24, 8'h07, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99),
         mk(8'h24, 8'h07, 8'h31, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_osc_stop_and_partial();
    logic [63:0] r, v;
    v = mk(8'h24, 8'h01, 8'h01, 8'h21, 8'h12, 8'h00, 8'h00, 8'h00);
    write_bits(v, 64);
    run_ticks(400);
    read_img(1'b1, r);
    chk("R10 stopped oscillator", r, v);
    write_bits(64'h5555_5555_5555_5555, 63);
    read_img(1'b1, r);
    chk("R12 partial write no commit", r, v);
  endtask

  task automatic t_snapshot();
    logic [63:0] r, v;
    v = mk(8'h24, 8'h06, 8'h06, 8'h04, 8'h08, 8'h15, 8'h30, 8'h45);
    write_bits(v, 64);
    read_img(1'b1, r);
    run_ticks(328);
    read_img(1'b0, r);
    chk("R11 snapshot held", r, v);
    read_img(1'b1, r);
    chk("R11 R12 fresh snapshot", r, mk(8'h24, 8'h06, 8'h06, 8'h04, 8'h08, 8'h15, 8'h30, 8'h46));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask_and_order();
    t_divider();
    t_cascade();
    t_twelve_hour();
    t_month_len();
    t_osc_stop_and_partial();
    t_snapshot();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule